// File: doc/BRIEF.md
# Indirect Host Register Port

This block is the slave side of an 8-bit asynchronous parallel host bus. The host never addresses internal registers directly. Each bus cycle carries a 3-bit port number: port 0 holds a register pointer, and port 1 moves data to or from the register that the pointer selects. After every port-1 access the pointer steps forward by one, so a host can stream through a table with a single pointer load followed by a run of data cycles.

A bus cycle is qualified by an active-low command pulse. For a read it is chip select OR'd with the read strobe, and for a write it is chip select OR'd with the write strobe. The pulse is brought into the system clock domain through a synchroniser. The block then drives a wait handshake output for a fixed number of system clocks while read data settles. After that it drives a ready handshake output until the pulse ends. The access takes effect when the pulse ends. Outside an access, the handshake outputs and the data bus are not driven. A mode input chooses the parallel host interface. When that input is low, the block ignores the bus.

Top module: `hbp_host_port`

## Requirements
- R1: An access is recognised only when `par_mode` is 1, `cs_n` is 0 and at least one of `rd_n` and `wr_n` is 0. A cycle with `rd_n` low is a read. Otherwise it is a write.
- R2: The command pulse passes through a synchroniser of `SYNC_STAGES` flops. The access commits once, after the pulse ends. Write data and port number are taken from the last samples made while the pulse was active.
- R3: Port encoding: `psel` 0 selects the pointer and 1 selects data. Writes to ports 2 to 7 change nothing, and reads from ports 2 to 7 return 8'h00.
- R4: Every committed port-1 access, read or write, adds one to the pointer. The pointer wraps from 8'hFF to 8'h00. A port-1 write stores `din` at the address the pointer held before the increment.
- R5: A port-0 write loads the pointer from `din`. A port-0 read returns the pointer and does not change it.
- R6: From the detected start of an access, `wait_n` is driven low for at least `WAIT_CYC` system clocks. Then `wait_n` goes high and `ready_n` is driven low until the pulse ends.
- R7: Outside an access, `wait_oe`, `ready_oe` and `dout_oe` are 0 (high impedance).
- R8: During a read, `dout_oe` is 1 and `dout` holds the read value by the time `ready_n` is first low. `dout_oe` stays 0 during writes.
- R9: While `par_mode` is 0, bus strobes cause no handshake and no change to the pointer or the registers.
- R10: After reset, the pointer and all registers are 0 and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode | input | 1 | 1 = parallel host interface enabled |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| psel | input | 3 | Target port number |
| din | input | 8 | Data from host |
| dout | output | 8 | Data to host |
| dout_oe | output | 1 | Drive enable for `dout` |
| wait_n | output | 1 | Wait handshake, active low |
| wait_oe | output | 1 | Drive enable for `wait_n` |
| ready_n | output | 1 | Ready handshake, active low |
| ready_oe | output | 1 | Drive enable for `ready_n` |

## Verification
The bench reads the pointer back after each port-1 read, port-1 write, port-0 read and unused-port write. A design that stepped the pointer on the wrong port, or stepped it twice for one pulse, would return a shifted pointer and shifted data. Loading the pointer with 8'hFF checks the wrap to 8'h00. The bench counts the wait cycles before ready and fails any design that signals ready early. A design that left any enable high after a pulse, or acted on strobes while the parallel mode was off, would show a stray drive or a moved pointer on the following read.

// File: rtl/hbp_pkg.sv
// Shared types for the indirect host register port.
// Assumes an 8-bit host data bus and a 3-bit port number.
package hbp_pkg;
    localparam int HBP_DW  = 8;
    localparam int HBP_PSW = 3;

    localparam logic [HBP_PSW-1:0] PORT_PTR  = 3'd0;
    localparam logic [HBP_PSW-1:0] PORT_DATA = 3'd1;

    // One host bus sample: direction, port and data
    typedef struct packed {
        logic               rd;
        logic [HBP_PSW-1:0] psel;
        logic [HBP_DW-1:0]  data;
    } hbp_xfer_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_WAIT  = 2'd1,
        HS_READY = 2'd2
    } hs_state_t;
endpackage

// File: rtl/hbp_strobe_sync.sv
// Brings the asynchronous command pulse and the bus fields into the
// system clock domain. Each field passes through a flop chain of the same
// depth as the strobe, so the fields seen with the synchronised strobe were
// sampled on the same edge as that strobe.
// Assumes the fields are stable for the whole active pulse.
module hbp_strobe_sync
    import hbp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_act,
    input  hbp_xfer_t bus_in,
    output logic      live,
    output logic      start,
    output logic      finish,
    output hbp_xfer_t bus_sync
);
    logic [STAGES:0] act_q;
    hbp_xfer_t       pipe_q [STAGES];

    // Strobe chain; the extra last stage is used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= {act_q[STAGES-1:0], cmd_act};
    end

    // Field chains, one stage per strobe stage
    for (genvar g = 0; g < STAGES; g++) begin : g_pipe
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[0] <= '0;
                else        pipe_q[0] <= bus_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= '0;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign live     = act_q[STAGES-1];
    assign start    = act_q[STAGES-1] & ~act_q[STAGES];
    assign finish   = ~act_q[STAGES-1] & act_q[STAGES];
    assign bus_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/hbp_handshake.sv
// Drives the wait and ready handshake and the data bus enable.
// Wait is held for WAIT_CYC clocks after the start of an access, then
// ready is held until the end of the pulse. Everything floats when idle.
module hbp_handshake
    import hbp_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    input  logic start_rd,
    output logic wait_n,
    output logic wait_oe,
    output logic ready_n,
    output logic ready_oe,
    output logic dout_oe
);
    localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYC - 1);

    hs_state_t     st;
    logic [CW-1:0] cnt;
    logic          rd_q;

    // Handshake phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= HS_IDLE;
            cnt  <= '0;
            rd_q <= 1'b0;
        end else if (finish) begin
            st   <= HS_IDLE;
            rd_q <= 1'b0;
        end else begin
            case (st)
                HS_IDLE: if (start) begin
                    st   <= HS_WAIT;
                    cnt  <= '0;
                    rd_q <= start_rd;
                end
                HS_WAIT: begin
                    if (cnt == CNT_LAST) st <= HS_READY;
                    else                 cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign wait_oe  = (st != HS_IDLE);
    assign ready_oe = (st != HS_IDLE);
    assign wait_n   = (st != HS_WAIT);
    assign ready_n  = (st != HS_READY);
    assign dout_oe  = rd_q;

    // R6: wait is held until the count reaches its limit
    a_r6_wait_min: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HS_WAIT && cnt != CNT_LAST && !finish) |=> (st == HS_WAIT));
    // R6: ready is entered only from the wait phase
    a_r6_ready_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == HS_READY) |-> $past(st == HS_WAIT));
endmodule

// File: rtl/hbp_regfile.sv
// Pointer register and internal register array reached through the ports.
// Looks up read data at the start of an access and commits the access
// when the pulse ends. Assumes at most one access is in flight.
module hbp_regfile
    import hbp_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              start,
    input  logic              finish,
    input  hbp_xfer_t         bus_sync,
    output logic [HBP_DW-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [HBP_DW-1:0] mem [DEPTH];
    logic [AW-1:0]     ptr;
    hbp_xfer_t         held;

    // Keep the last sample made while the pulse was active
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (live) held <= bus_sync;
    end

    // Read value lookup at the start of an access
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (start && bus_sync.rd) begin
            case (bus_sync.psel)
                PORT_PTR:  rdata <= HBP_DW'(ptr);
                PORT_DATA: rdata <= mem[ptr];
                default:   rdata <= '0;
            endcase
        end
    end

    // Commit of pointer and register updates at the end of the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (finish) begin
            if (held.psel == PORT_PTR && !held.rd) ptr <= AW'(held.data);
            if (held.psel == PORT_DATA) begin
                if (!held.rd) mem[ptr] <= held.data;
                ptr <= ptr + 1'b1;
            end
        end
    end

    // R4: a data-port access steps the pointer by exactly one
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && held.psel == PORT_DATA) |=> (ptr == AW'($past(ptr) + 1'b1)));
    // R4: a data-port write lands at the old pointer
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && held.psel == PORT_DATA && !held.rd)
        |=> (mem[$past(ptr)] == $past(held.data)));
    // R5: the pointer moves only on a commit
    a_r5_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(ptr));
    // R3: unused ports leave the pointer alone
    a_r3_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && held.psel > PORT_DATA) |=> $stable(ptr));
endmodule

// File: rtl/hbp_host_port.sv
// Top of the indirect host register port. Forms the command pulse from
// chip select and the strobes, synchronises it, and connects the
// handshake and the register array.
// Assumes the host follows the minimum pulse and gap timing.
module hbp_host_port
    import hbp_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [HBP_PSW-1:0] psel,
    input  logic [HBP_DW-1:0] din,
    output logic [HBP_DW-1:0] dout,
    output logic              dout_oe,
    output logic              wait_n,
    output logic              wait_oe,
    output logic              ready_n,
    output logic              ready_oe
);
    logic      cmd_act;
    hbp_xfer_t bus_raw;
    hbp_xfer_t bus_sync;
    logic      live, start, finish;

    // Active-high command: chip select with either strobe, parallel mode only
    assign cmd_act = par_mode & ~cs_n & (~rd_n | ~wr_n);
    assign bus_raw = '{rd: ~rd_n, psel: psel, data: din};

    hbp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_act  (cmd_act),
        .bus_in   (bus_raw),
        .live     (live),
        .start    (start),
        .finish   (finish),
        .bus_sync (bus_sync)
    );

    hbp_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .finish   (finish),
        .start_rd (bus_sync.rd),
        .wait_n   (wait_n),
        .wait_oe  (wait_oe),
        .ready_n  (ready_n),
        .ready_oe (ready_oe),
        .dout_oe  (dout_oe)
    );

    hbp_regfile #(.DEPTH(DEPTH)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .start    (start),
        .finish   (finish),
        .bus_sync (bus_sync),
        .rdata    (dout)
    );

    // R2: a commit only happens inside a handshaked access
    a_r2_finish_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> wait_oe);
    // R8: the data bus is driven only inside an access
    a_r8_doe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> ready_oe);
endmodule

// File: tb/sim_hbp_host_port.sv
module sim_hbp_host_port;
    localparam int WAIT_CYC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_mode = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] psel = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe, wait_n, wait_oe, ready_n, ready_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         popped = 1'b0;

    always #5 clk = ~clk;

    hbp_host_port #(.WAIT_CYC(WAIT_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .psel(psel), .din(din), .dout(dout),
        .dout_oe(dout_oe), .wait_n(wait_n), .wait_oe(wait_oe),
        .ready_n(ready_n), .ready_oe(ready_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: on the first ready of a read, compare the bus with the queue
    always @(negedge clk) begin
        if (cs_n) popped = 1'b0;
        else if (!rd_n && ready_oe && !ready_n && !popped) begin
            popped = 1'b1;
            if (exp_q.size() == 0) check(1'b0, "R8 unexpected read", dout, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dout_oe && dout == e, t, {dout_oe, dout}, {1'b1, e});
            end
        end
    end

    // Driver: one host bus cycle; reads push their expected value
    task automatic host_cycle(input bit is_rd, input logic [2:0] port,
                              input logic [7:0] val, input bit hs, input string tag);
        int waits = 0;
        int guard = 0;
        bit saw_doe = 0;
        bit saw_oe = 0;
        bit got_ready = 0;
        @(negedge clk);
        psel = port;
        din  = val;
        cs_n = 1'b0;
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        if (is_rd && hs) begin exp_q.push_back(val); tag_q.push_back(tag); end
        while (guard < 24 && !got_ready) begin
            @(negedge clk);
            guard++;
            if (wait_oe && !wait_n) waits++;
            if (dout_oe) saw_doe = 1;
            if (wait_oe || ready_oe || dout_oe) saw_oe = 1;
            if (ready_oe && !ready_n) got_ready = 1;
        end
        if (hs) check(got_ready && waits >= WAIT_CYC, "R6 wait cycles", waits, WAIT_CYC);
        else    check(!saw_oe, "R9 no handshake in serial mode", saw_oe, 0);
        if (hs && !is_rd) check(!saw_doe, "R8 no drive on write", saw_doe, 0);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        din = 8'hxx ^ 8'h00;
        din = ~val;
        repeat (3) @(negedge clk);
        check(!wait_oe && !ready_oe && !dout_oe, "R7 idle high-Z",
              {wait_oe, ready_oe, dout_oe}, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wait_oe && !ready_oe && !dout_oe, "R10 reset enables", {wait_oe, ready_oe, dout_oe}, 0);
        host_cycle(1, 3'd0, 8'h00, 1, "R10 reset pointer");
        host_cycle(1, 3'd1, 8'h00, 1, "R10 reset register");
        // R5 load pointer, R4 write stream
        host_cycle(0, 3'd0, 8'h10, 1, "");
        host_cycle(0, 3'd1, 8'hA5, 1, "");
        host_cycle(0, 3'd1, 8'h3C, 1, "");
        host_cycle(1, 3'd0, 8'h12, 1, "R4 pointer after two writes");
        host_cycle(1, 3'd0, 8'h12, 1, "R5 port-0 read keeps pointer");
        host_cycle(0, 3'd0, 8'h10, 1, "");
        host_cycle(1, 3'd1, 8'hA5, 1, "R4 read first stored");
        host_cycle(1, 3'd1, 8'h3C, 1, "R4 read second stored");
        host_cycle(1, 3'd0, 8'h12, 1, "R4 pointer after reads");
        // R3 unused ports
        host_cycle(0, 3'd3, 8'h77, 1, "");
        host_cycle(1, 3'd0, 8'h12, 1, "R3 unused write keeps pointer");
        host_cycle(1, 3'd1, 8'h00, 1, "R3 unused write stores nothing");
        host_cycle(1, 3'd5, 8'h00, 1, "R3 unused read is zero");
        host_cycle(1, 3'd0, 8'h13, 1, "R3 unused read keeps pointer");
        // R4 wrap
        host_cycle(0, 3'd0, 8'hFF, 1, "");
        host_cycle(0, 3'd1, 8'h5A, 1, "");
        host_cycle(1, 3'd0, 8'h00, 1, "R4 pointer wraps");
        host_cycle(0, 3'd0, 8'hFF, 1, "");
        host_cycle(1, 3'd1, 8'h5A, 1, "R4 top entry kept");
        // R9 serial mode ignores the bus
        par_mode = 1'b0;
        host_cycle(0, 3'd0, 8'h40, 0, "");
        host_cycle(0, 3'd1, 8'hEE, 0, "");
        par_mode = 1'b1;
        host_cycle(1, 3'd0, 8'h00, 1, "R9 pointer unchanged");
        host_cycle(1, 3'd1, 8'h00, 1, "R9 register unchanged");
        // R1 chip select high blocks an access
        @(negedge clk);
        psel = 3'd0; din = 8'h66; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check(!wait_oe, "R1 no access without select", wait_oe, 0);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        host_cycle(1, 3'd0, 8'h01, 1, "R1 pointer not loaded");
        check(exp_q.size() == 0, "R2 one result per read", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule